// File: doc/BRIEF.md
# ADC Capture and Strobe Sequencer

This block paces a 12-bit parallel-output analog-to-digital converter and captures its results. A free-running counter raises a one-cycle encode pulse at a fixed sample rate. The converter answers each encode with an active-low data-available pulse (`dav_n`) and holds its result word on the data bus until the next conversion. The block delays that pulse twice, preserving its width. The first delay matches the timing of an older, slower converter. Its output leaves the block as the active-low data strobe (`strobe_n`), whose rising edge tells a downstream board to take the word. The second, shorter delay forms an internal latch strobe. On that strobe's rising edge the converter word is loaded into the output register `word`.

All delays are whole clock cycles, computed from parameters in nanoseconds and MHz and rounded up: D1 = ceil(DLY1_NS·CLK_MHZ/1000), D2 = ceil(DLY2_NS·CLK_MHZ/1000), PER = ceil(PERIOD_NS·CLK_MHZ/1000). The defaults are 200 MHz, 450 ns, 60 ns and 2000 ns. This gives D1 = 90, D2 = 12 and PER = 400.

A single active-low clear input, `clr_n`, carries both the power-up reset and the conversion-error condition, combined outside the block. It zeroes the held word and discards any data-available pulse still in flight. `dav_n` and `adc_d` are assumed synchronous to `clk`.

Top module: `adc_strobe_seq`

## Requirements
- R1: While `rst_n` is low, `word` is 0, `strobe_n` is 1 and `enc` is 0.
- R2: `enc` is high for exactly one cycle. The first pulse comes PER cycles after the first clock edge that samples `rst_n` high, and the pulses then repeat every PER cycles.
- R3: If edge t is the first clock edge that samples `dav_n` low, `strobe_n` goes low at edge t+D1−1.
- R4: If edge u is the first clock edge that samples `dav_n` high again, `strobe_n` returns high at edge u+D1−1, so the strobe is as wide as the data-available pulse.
- R5: With edge u as in R4, `word` loads `adc_d` at edge u+D1+D2−1, which is D2 cycles after `strobe_n` rises. `word` does not change at any other time unless a clear occurs.
- R6: `word` bit 0 is the LSB and bit 11 the MSB, copied bit for bit from `adc_d`. All zeros (0x000, bottom of range) and all ones (0xFFF, full scale) pass unchanged.
- R7: A clock edge that samples `clr_n` low sets `word` to 0 and `strobe_n` to 1. It also discards any data-available pulse still in the delay, so that pulse produces no strobe and no load afterwards.
- R8: A data-available pulse that arrives while `clr_n` is held low is ignored. `word` stays 0 and `strobe_n` stays 1. After `clr_n` returns high, the next conversion is captured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low clear (power-up or conversion error) |
| dav_n | input | 1 | Converter data-available pulse, active low |
| adc_d | input | 12 | Converter result, bit 0 = LSB |
| enc | output | 1 | One-cycle encode (start-conversion) pulse |
| strobe_n | output | 1 | Active-low downstream data strobe |
| word | output | 12 | Latched converter word |

## Verification
A wrong tap on the delay line moves the edges of `strobe_n` by whole cycles. This shows within about one hundred cycles of the first data-available pulse after reset. A wrong load condition makes `word` change on the wrong cycle, or not at all. That shows at the end of the first conversion, D1+D2 cycles after `dav_n` returns high. A delay line that a clear fails to flush leaks a late strobe or a nonzero word in the sample that straddles the clear. A wrong encode counter shows as a period other than PER between two encode pulses.

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq #(
  parameter int CLK_MHZ   = 200,
  parameter int DLY1_NS   = 450,
  parameter int DLY2_NS   = 60,
  parameter int PERIOD_NS = 2000,
  parameter int DW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          dav_n,
  input  logic [DW-1:0] adc_d,
  output logic          enc,
  output logic          strobe_n,
  output logic [DW-1:0] word
);
  localparam int D1  = (DLY1_NS * CLK_MHZ + 999) / 1000;
  localparam int D2  = (DLY2_NS * CLK_MHZ + 999) / 1000;
  localparam int L   = D1 + D2;
  localparam int PER = (PERIOD_NS * CLK_MHZ + 999) / 1000;
  localparam int CW  = $clog2(PER);

  logic [L-1:0]  line;
  logic [CW-1:0] cnt;
  wire           flush = !rst_n || !clr_n;
  wire           take  = line[L-2] & ~line[L-1];

  always_ff @(posedge clk)
    if (flush) line <= '1;
    else       line <= {line[L-2:0], dav_n};

  assign strobe_n = line[D1-1];

  always_ff @(posedge clk)
    if (flush)     word <= '0;
    else if (take) word <= adc_d;

  always_ff @(posedge clk)
    if (!rst_n) begin
      cnt <= '0;
      enc <= 1'b0;
    end else begin
      enc <= (cnt == CW'(PER - 1));
      cnt <= (cnt == CW'(PER - 1)) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/adc_strobe_seq_chk.sv
module adc_strobe_seq_chk #(
  parameter int D2  = 12,
  parameter int PER = 400,
  parameter int DW  = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          enc,
  input logic          strobe_n,
  input logic [DW-1:0] word
);
  logic        s_prev;
  logic [15:0] since;
  logic [15:0] ecnt;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s_prev <= 1'b1;
      since  <= 16'hffff;
      ecnt   <= '0;
    end else begin
      s_prev <= strobe_n;
      if (strobe_n && !s_prev) since <= 16'd1;
      else if (since != 16'hffff) since <= since + 16'd1;
      ecnt <= enc ? 16'd1 : ecnt + 16'd1;
    end

  // R2
  enc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc |=> !enc);

  // R2
  enc_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc |-> ecnt == 16'(PER));

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (word == '0 && strobe_n));

  // R5
  latch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && word != $past(word)) |-> since == 16'(D2));
endmodule

bind adc_strobe_seq adc_strobe_seq_chk #(.D2(D2), .PER(PER), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .enc(enc),
  .strobe_n(strobe_n), .word(word)
);

// File: tb/adc_strobe_seq_test.sv
`timescale 1ns/1ps
module adc_strobe_seq_test;
  localparam int CLK_MHZ = 200;
  localparam int P_NS    = 1000;
  localparam int D1   = (450 * CLK_MHZ + 999) / 1000;
  localparam int D2   = (60 * CLK_MHZ + 999) / 1000;
  localparam int L    = D1 + D2;
  localparam int PER  = (P_NS * CLK_MHZ + 999) / 1000;
  localparam int CONV = 40;
  localparam int W    = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clr_n, dav_n, enc, strobe_n;
  logic [11:0] adc_d, word;

  adc_strobe_seq #(.CLK_MHZ(CLK_MHZ), .PERIOD_NS(P_NS)) uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dav_n(dav_n), .adc_d(adc_d),
    .enc(enc), .strobe_n(strobe_n), .word(word)
  );

  int total = 0, bad = 0, steps = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    steps++;
  endtask

  task automatic wait_enc();
    do tick(); while (!enc);
  endtask

  // mode 0: normal, 1: clear held by caller, 2: clear pulse mid-delay
  task automatic do_sample(input logic [11:0] v, input int mode, input string tag);
    logic [11:0] old;
    old = word;
    tick();
    chk(!enc, "R2", "enc width", enc, 0);
    repeat (CONV - 1) tick();
    adc_d = v;
    dav_n = 1'b0;
    for (int j = 1; j <= W + L + 1; j++) begin
      tick();
      if (j == W) dav_n = 1'b1;
      if (mode == 2 && j == W + 10) clr_n = 1'b0;
      if (mode == 2 && j == W + 11) clr_n = 1'b1;
      if (mode == 0) begin
        if (j == D1 - 1)     chk(strobe_n == 1'b1, "R3", "strobe before fall", strobe_n, 1);
        if (j == D1)         chk(strobe_n == 1'b0, "R3", "strobe fall", strobe_n, 0);
        if (j == W + D1 - 1) chk(strobe_n == 1'b0, "R4", "strobe before rise", strobe_n, 0);
        if (j == W + D1)     chk(strobe_n == 1'b1, "R4", "strobe rise", strobe_n, 1);
        if (j == W + L - 1)  chk(word == old, "R5", "word before latch", word, old);
        if (j == W + L)      chk(word == v, tag, "word latched", word, v);
      end else begin
        if (j == D1 || j == W + D1 - 1)
          chk(strobe_n == 1'b1, mode == 1 ? "R8" : "R7", "strobe suppressed", strobe_n, 1);
        if (j == W + L + 1)
          chk(word == 12'h000, mode == 1 ? "R8" : "R7", "word held zero", word, 0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; dav_n = 1'b1; adc_d = '0;
    repeat (5) @(negedge clk);
    chk(word == 12'h000, "R1", "reset word", word, 0);
    chk(strobe_n == 1'b1, "R1", "reset strobe", strobe_n, 1);
    chk(enc == 1'b0, "R1", "reset enc", enc, 0);
    rst_n = 1'b1;
    steps = 0;
    wait_enc();
    chk(steps == PER, "R2", "first encode", steps, PER);

    steps = 0;
    do_sample(12'h000, 0, "R6"); wait_enc();
    chk(steps == PER, "R2", "period", steps, PER);
    steps = 0;
    do_sample(12'hfff, 0, "R6"); wait_enc();
    chk(steps == PER, "R2", "period", steps, PER);
    for (int b = 0; b < 12; b++) begin
      steps = 0;
      do_sample(12'(1 << b), 0, "R6"); wait_enc();
      chk(steps == PER, "R2", "period", steps, PER);
    end
    for (int v = 0; v < 4096; v += 17) begin
      steps = 0;
      do_sample(12'(v), 0, "R5"); wait_enc();
      chk(steps == PER, "R2", "period", steps, PER);
    end

    do_sample(12'habc, 0, "R5");
    clr_n = 1'b0;
    tick();
    chk(word == 12'h000, "R7", "clear word", word, 0);
    chk(strobe_n == 1'b1, "R7", "clear strobe", strobe_n, 1);
    wait_enc();
    do_sample(12'h555, 1, "R8");
    clr_n = 1'b1;
    wait_enc();
    do_sample(12'h123, 0, "R8");
    wait_enc();
    do_sample(12'h777, 2, "R7");
    wait_enc();
    do_sample(12'h9e4, 0, "R5");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule